// File: doc/BRIEF.md
# Cell Receiver Interrupt Status Register

This block collects three event sources of an ATM cell receiver into one byte-wide status register that a host processor polls or services from an interrupt. The sources are a header-check byte error found in an incoming cell, a change in the loss-of-cell-delineation condition, and the capture of a maintenance cell into the receive maintenance-cell buffer. Each latched bit stays set until the host reads the status register. The read clears it.

The delineation state (HUNT, PRE-SYNC, SYNC) arrives as a live input. The block tracks it and keeps a live loss-of-delineation flag, which is readable at bit 7 of a separate status address. A change-of-delineation interrupt alone does not say which way the receiver moved, so the host reads this flag to tell the two cases apart. A per-bit enable mask decides which latched bits drive the interrupt request line.

Top module: `cellrx_irq_regs`

## Requirements
- R1: After reset, all latched status bits and all mask bits are 0, `lod_o` is 1, `irq_o` is 0, and the tracked delineation state is HUNT. The state encoding is HUNT=2'b00, PRE-SYNC=2'b01, SYNC=2'b10.
- R2: A one-cycle pulse on `hdr_err_i` sets status bit 0. The bit stays set until the status register is read.
- R3: A one-cycle pulse on `mcell_i` sets status bit 2. The bit stays set until the status register is read.
- R4: A move from SYNC to HUNT on `delin_state_i` sets status bit 1 and drives `lod_o` to 1 in the cycle after the input changes.
- R5: A move from PRE-SYNC to SYNC sets status bit 1 and drives `lod_o` to 0 in the cycle after the input changes.
- R6: Any other pair of consecutive states, including an unchanged state, leaves status bit 1 and `lod_o` untouched.
- R7: A read at the status address (default 0) returns the latched bits in [2:0] with bits [7:3] at 0 on `rd_data_o` in the cycle after `rd_en_i`. The same read clears bits [2:0].
- R8: An event that arrives in the same cycle as a status read is not lost. The read returns the earlier value, and the bit is set afterwards.
- R9: `irq_o` is the OR over bits [2:0] of the status bit ANDed with the matching mask bit. The mask is written and read at the mask address (default 1) in bits [2:0], and its upper bits read as 0.
- R10: A read at the live address (default 2) returns `lod_o` in bit 7 and 0 in all other bits. This read does not clear status.
- R11: A write to the status or live address has no effect. A read of an unmapped address returns 0 and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_err_i | input | 1 | Header-check error event pulse |
| mcell_i | input | 1 | Maintenance cell captured event pulse |
| delin_state_i | input | 2 | Current delineation state (HUNT/PRE-SYNC/SYNC) |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W | Register read address |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_data_o | output | DATA_W | Register read data, one cycle after the strobe |
| lod_o | output | 1 | Live loss-of-delineation flag |
| irq_o | output | 1 | Masked interrupt request |

## Verification
Each combination of the two pulse events is applied twice: once on its own, followed by two reads, and once in the same cycle as a read. This separates a plain latch, a clear on read, and the case where an event coincides with a read. Every ordered pair of the three delineation states is driven as a transition. The status read and the live flag then show that only the two defined moves raise the change interrupt, and that each move drives the flag in its own direction. All 64 pairs of mask value and status pattern are checked against the expected masked OR on the request line. Writes to read-only addresses and reads of an unmapped address are followed by reads that show nothing changed.

// File: rtl/cellrx_irq_pkg.sv
package cellrx_irq_pkg;

   typedef enum logic [1:0] {
      DS_HUNT    = 2'b00,
      DS_PRESYNC = 2'b01,
      DS_SYNC    = 2'b10,
      DS_RSVD    = 2'b11
   } delin_state_e;

   localparam int unsigned EVT_HDR   = 0;
   localparam int unsigned EVT_DELIN = 1;
   localparam int unsigned EVT_MCELL = 2;
   localparam int unsigned NUM_EVT   = 3;

endpackage

// File: rtl/cellrx_sticky_bit.sv
module cellrx_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic clr_i,
   input  logic en_i,
   output logic bit_o,
   output logic req_o
);

   logic bit_q;

   // Event has priority over clear so a coincident event survives the read.
   always_ff @(posedge clk) begin
      if (!rst_n)      bit_q <= 1'b0;
      else if (evt_i)  bit_q <= 1'b1;
      else if (clr_i)  bit_q <= 1'b0;
   end

   assign bit_o = bit_q;
   assign req_o = bit_q & en_i;

   AST_EVT_SETS:  assert property (@(posedge clk) disable iff (!rst_n) evt_i |=> bit_o);            // R8
   AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (clr_i && !evt_i) |=> !bit_o); // R7
   AST_HOLD_SET:  assert property (@(posedge clk) disable iff (!rst_n) (bit_o && !clr_i) |=> bit_o);  // R2

endmodule

// File: rtl/cellrx_delin_track.sv
module cellrx_delin_track
   import cellrx_irq_pkg::*;
#(
   parameter bit LOD_RESET = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] state_i,
   output logic       lod_o,
   output logic       chg_o
);

   delin_state_e prev_q;
   delin_state_e cur;
   logic         lost;
   logic         found;
   logic         lod_q;

   assign cur   = delin_state_e'(state_i);
   assign lost  = (prev_q == DS_SYNC)    && (cur == DS_HUNT);
   assign found = (prev_q == DS_PRESYNC) && (cur == DS_SYNC);
   assign chg_o = lost | found;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= DS_HUNT;
         lod_q  <= LOD_RESET;
      end else begin
         prev_q <= cur;
         if (lost)       lod_q <= 1'b1;
         else if (found) lod_q <= 1'b0;
      end
   end

   assign lod_o = lod_q;

   AST_LOD_RISE:   assert property (@(posedge clk) disable iff (!rst_n)
                      (prev_q == DS_SYNC && state_i == 2'b00) |=> lod_o);      // R4
   AST_LOD_FALL:   assert property (@(posedge clk) disable iff (!rst_n)
                      (prev_q == DS_PRESYNC && state_i == 2'b10) |=> !lod_o);  // R5
   AST_LOD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
                      !chg_o |=> $stable(lod_o));                              // R6

endmodule

// File: rtl/cellrx_reg_port.sv
module cellrx_reg_port #(
   parameter int unsigned ADDR_W        = 4,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned NUM_EVT       = 3,
   parameter int unsigned STAT_ADDR     = 0,
   parameter int unsigned MASK_ADDR     = 1,
   parameter int unsigned LIVE_ADDR     = 2,
   parameter int unsigned LOD_BIT       = 7,
   parameter bit          RD_REGISTERED = 1'b1,
   parameter logic [NUM_EVT-1:0] MASK_RESET = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_en_i,
   input  logic [ADDR_W-1:0]  rd_addr_i,
   input  logic               wr_en_i,
   input  logic [ADDR_W-1:0]  wr_addr_i,
   input  logic [DATA_W-1:0]  wr_data_i,
   input  logic [NUM_EVT-1:0] stat_i,
   input  logic               lod_i,
   output logic [NUM_EVT-1:0] mask_o,
   output logic               stat_clr_o,
   output logic [DATA_W-1:0]  rd_data_o
);

   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);
   localparam logic [ADDR_W-1:0] A_LIVE = ADDR_W'(LIVE_ADDR);

   if (DATA_W < NUM_EVT || LOD_BIT >= DATA_W) begin : g_bad_width
      $error("cellrx_reg_port: data width too small for fields");
   end
   if (STAT_ADDR == MASK_ADDR || STAT_ADDR == LIVE_ADDR || MASK_ADDR == LIVE_ADDR) begin : g_bad_map
      $error("cellrx_reg_port: register addresses must differ");
   end
   if (STAT_ADDR >= (1 << ADDR_W) || MASK_ADDR >= (1 << ADDR_W) || LIVE_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("cellrx_reg_port: address outside decode range");
   end

   logic [NUM_EVT-1:0] mask_q;
   logic [DATA_W-1:0]  rd_mux;
   logic               hit_mask_wr;
   logic               rd_mapped;
   logic               unused_wr_hi;

   assign hit_mask_wr  = wr_en_i && (wr_addr_i == A_MASK);
   assign stat_clr_o   = rd_en_i && (rd_addr_i == A_STAT);
   assign rd_mapped    = (rd_addr_i == A_STAT) || (rd_addr_i == A_MASK) || (rd_addr_i == A_LIVE);
   assign unused_wr_hi = ^wr_data_i;

   always_ff @(posedge clk) begin
      if (!rst_n)           mask_q <= MASK_RESET;
      else if (hit_mask_wr) mask_q <= wr_data_i[NUM_EVT-1:0];
   end
   assign mask_o = mask_q;

   always_comb begin
      rd_mux = '0;
      if (rd_addr_i == A_STAT)      rd_mux[NUM_EVT-1:0] = stat_i;
      else if (rd_addr_i == A_MASK) rd_mux[NUM_EVT-1:0] = mask_q;
      else if (rd_addr_i == A_LIVE) rd_mux[LOD_BIT]     = lod_i;
   end

   if (RD_REGISTERED) begin : g_rd_reg
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk) begin
         if (!rst_n)       rd_q <= '0;
         else if (rd_en_i) rd_q <= rd_mux;
      end
      assign rd_data_o = rd_q;

      AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                            (rd_en_i && !rd_mapped) |=> (rd_data_o == '0));     // R11
   end else begin : g_rd_comb
      assign rd_data_o = rd_en_i ? rd_mux : '0;
   end

   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                     !hit_mask_wr |=> $stable(mask_o));                        // R9

endmodule

// File: rtl/cellrx_irq_regs.sv
module cellrx_irq_regs
   import cellrx_irq_pkg::*;
#(
   parameter int unsigned ADDR_W        = 4,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned STAT_ADDR     = 0,
   parameter int unsigned MASK_ADDR     = 1,
   parameter int unsigned LIVE_ADDR     = 2,
   parameter int unsigned LOD_BIT       = 7,
   parameter bit          RD_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hdr_err_i,
   input  logic              mcell_i,
   input  logic [1:0]        delin_state_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              lod_o,
   output logic              irq_o
);

   logic [NUM_EVT-1:0] evt;
   logic [NUM_EVT-1:0] stat;
   logic [NUM_EVT-1:0] mask;
   logic [NUM_EVT-1:0] req;
   logic               delin_chg;
   logic               stat_clr;

   cellrx_delin_track #(.LOD_RESET(1'b1)) u_delin (
      .clk     (clk),
      .rst_n   (rst_n),
      .state_i (delin_state_i),
      .lod_o   (lod_o),
      .chg_o   (delin_chg)
   );

   assign evt[EVT_HDR]   = hdr_err_i;
   assign evt[EVT_DELIN] = delin_chg;
   assign evt[EVT_MCELL] = mcell_i;

   for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
      cellrx_sticky_bit u_bit (
         .clk   (clk),
         .rst_n (rst_n),
         .evt_i (evt[i]),
         .clr_i (stat_clr),
         .en_i  (mask[i]),
         .bit_o (stat[i]),
         .req_o (req[i])
      );
   end

   cellrx_reg_port #(
      .ADDR_W        (ADDR_W),
      .DATA_W        (DATA_W),
      .NUM_EVT       (NUM_EVT),
      .STAT_ADDR     (STAT_ADDR),
      .MASK_ADDR     (MASK_ADDR),
      .LIVE_ADDR     (LIVE_ADDR),
      .LOD_BIT       (LOD_BIT),
      .RD_REGISTERED (RD_REGISTERED),
      .MASK_RESET    ('0)
   ) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_en_i    (rd_en_i),
      .rd_addr_i  (rd_addr_i),
      .wr_en_i    (wr_en_i),
      .wr_addr_i  (wr_addr_i),
      .wr_data_i  (wr_data_i),
      .stat_i     (stat),
      .lod_i      (lod_o),
      .mask_o     (mask),
      .stat_clr_o (stat_clr),
      .rd_data_o  (rd_data_o)
   );

   assign irq_o = |req;

   AST_IRQ_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
                       irq_o |-> ((stat & mask) != '0));                   // R9
   AST_HDR_LATCH:   assert property (@(posedge clk) disable iff (!rst_n)
                       hdr_err_i |=> stat[EVT_HDR]);                       // R2
   AST_MCELL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
                       mcell_i |=> stat[EVT_MCELL]);                       // R3

endmodule

// File: tb/cellrx_irq_regs_test.sv
`timescale 1ns/1ps
module cellrx_irq_regs_test;

   localparam logic [3:0] A_STAT = 4'd0;
   localparam logic [3:0] A_MASK = 4'd1;
   localparam logic [3:0] A_LIVE = 4'd2;
   localparam logic [1:0] HUNT = 2'b00, PRESYNC = 2'b01, SYNC = 2'b10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hdr_err_i = 1'b0;
   logic       mcell_i = 1'b0;
   logic [1:0] delin_state_i = HUNT;
   logic       rd_en_i = 1'b0;
   logic [3:0] rd_addr_i = '0;
   logic       wr_en_i = 1'b0;
   logic [3:0] wr_addr_i = '0;
   logic [7:0] wr_data_i = '0;
   logic [7:0] rd_data_o;
   logic       lod_o;
   logic       irq_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [1:0] m_prev = HUNT;
   logic       m_lod = 1'b1;
   logic       m_chg = 1'b0;

   always #4 clk = ~clk;

   cellrx_irq_regs uut (
      .clk(clk), .rst_n(rst_n), .hdr_err_i(hdr_err_i), .mcell_i(mcell_i),
      .delin_state_i(delin_state_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .rd_data_o(rd_data_o), .lod_o(lod_o), .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic do_read(input logic [3:0] a, output logic [7:0] d);
      rd_en_i = 1'b1; rd_addr_i = a;
      @(negedge clk);
      rd_en_i = 1'b0;
      d = rd_data_o;
   endtask

   task automatic do_write(input logic [3:0] a, input logic [7:0] v);
      wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = v;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic pulse(input logic h, input logic m, input logic with_rd, output logic [7:0] d);
      hdr_err_i = h; mcell_i = m;
      rd_en_i = with_rd; rd_addr_i = A_STAT;
      @(negedge clk);
      hdr_err_i = 1'b0; mcell_i = 1'b0; rd_en_i = 1'b0;
      d = rd_data_o;
   endtask

   task automatic set_state(input logic [1:0] s);
      m_chg = ((m_prev == SYNC) && (s == HUNT)) || ((m_prev == PRESYNC) && (s == SYNC));
      if ((m_prev == SYNC) && (s == HUNT)) m_lod = 1'b1;
      if ((m_prev == PRESYNC) && (s == SYNC)) m_lod = 1'b0;
      m_prev = s;
      delin_state_i = s;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic [7:0] e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 lod", {7'b0, lod_o}, 8'h01);
      check("R1 irq", {7'b0, irq_o}, 8'h00);
      do_read(A_STAT, d); check("R1 status", d, 8'h00);
      do_read(A_MASK, d); check("R1 mask", d, 8'h00);
      do_read(A_LIVE, d); check("R10 live after reset", d, 8'h80);

      // R2 R3 R7 R8 event sweep
      for (int ev = 0; ev < 4; ev++) begin
         e = {5'b0, ev[1], 1'b0, ev[0]};
         pulse(ev[0], ev[1], 1'b0, d);
         do_read(A_STAT, d); check("R2/R3 latched", d, e);
         do_read(A_STAT, d); check("R7 cleared by read", d, 8'h00);
         pulse(ev[0], ev[1], 1'b1, d); check("R8 read with event returns old", d, 8'h00);
         do_read(A_STAT, d); check("R8 event kept", d, e);
      end

      // R4 R5 R6 transition sweep
      for (int a = 0; a < 3; a++) begin
         for (int b = 0; b < 3; b++) begin
            set_state(2'(a));
            do_read(A_STAT, d);
            set_state(2'(b));
            do_read(A_STAT, d);
            check("R4/R5/R6 change bit", d, m_chg ? 8'h02 : 8'h00);
            check("R4/R5/R6 lod", {7'b0, lod_o}, {7'b0, m_lod});
            do_read(A_LIVE, d);
            check("R10 live flag", d, {m_lod, 7'b0});
         end
      end
      set_state(HUNT);
      do_read(A_STAT, d);

      // R9 mask and status sweep
      for (int m = 0; m < 8; m++) begin
         do_write(A_MASK, {5'b11111, 3'(m)});
         do_read(A_MASK, d); check("R9 mask readback", d, {5'b0, 3'(m)});
         for (int s = 0; s < 8; s++) begin
            do_read(A_STAT, d);
            if (s[1]) begin
               set_state(PRESYNC); set_state(SYNC); set_state(HUNT);
            end
            pulse(s[0], s[2], 1'b0, d);
            check("R9 irq", {7'b0, irq_o}, {7'b0, |(3'(s) & 3'(m))});
         end
      end
      do_write(A_MASK, 8'h00);

      // R11 read-only and unmapped addresses
      do_read(A_STAT, d);
      pulse(1'b1, 1'b0, 1'b0, d);
      do_write(A_STAT, 8'h00);
      do_read(4'd7, d); check("R11 unmapped reads zero", d, 8'h00);
      do_read(A_LIVE, d); check("R10 live read", d, {m_lod, 7'b0});
      do_read(A_STAT, d); check("R11 status unchanged by write/unmapped read", d, 8'h01);
      do_write(A_LIVE, 8'h00);
      check("R11 live write ignored", {7'b0, lod_o}, {7'b0, m_lod});

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule